// File: doc/BRIEF.md
# Comparator Offset Trim Sequencer

This block is the digital controller that cancels the input-referred offset of a charge-redistribution converter. While the calibration enable is high it takes over the sample and top-plate-short controls of the capacitor arrays. It leads the arrays through three timed phases on the converter clock. It then builds a 5-bit trim code from a run of comparator decisions.

The phases are named in order. In `ST_REF_SAMPLE` the references are sampled onto the bottom plates. In `ST_DISCHARGE` every element is tied to common mode while the top plates stay shorted. In `ST_TRIM` the comparator clock is enabled and the code tracks the comparator's decisions. The code weights five binary trim elements (1, 2, 4, 8 and 16 units) on the positive array. The matching negative-array elements are always sent to the opposite reference. After exactly 32 decisions the sequencer parks in `ST_DONE` and flags completion. The code is then held for normal conversions until a later calibration restarts it.

The FSM has five states and these transitions:
- `ST_IDLE` goes to `ST_REF_SAMPLE` when the enable is high.
- `ST_REF_SAMPLE` goes to `ST_DISCHARGE` when its phase timer expires.
- `ST_DISCHARGE` goes to `ST_TRIM` after one cycle.
- `ST_TRIM` goes to `ST_DONE` on the 32nd decision.
- Every state other than `ST_IDLE` returns to `ST_IDLE` on the clock edge that sees the enable low.

Top module: `ocal_ctrl`

## Requirements
- R1: After reset the block is idle with `cal_mode`, `cal_samp`, `cal_short`, `cmp_clk_en` and `cal_done` low, `sw_cm` all zero and `trim_code` equal to 0.
- R2: On the first clock edge in `ST_IDLE` with `cal_en` high, the block enters `ST_REF_SAMPLE` and clears `trim_code` to 0. It then drives `cal_mode`, `cal_samp` and `cal_short` high for SAMPLE_CYCLES cycles (default 2) with `sw_cm` all zero.
- R3: `ST_DISCHARGE` lasts exactly one cycle. In it `cal_samp` is low, `cal_short` is high and all 11 bits of `sw_cm` are high. `cal_short` therefore falls one cycle after `cal_samp`.
- R4: In `ST_TRIM`, `cmp_clk_en` and `cal_mode` are high and `cal_samp` and `cal_short` are low. `sw_cm` has bits 10..5 (the non-trim elements) high and bits 4..0 (the trim elements) low.
- R5: In `ST_TRIM`, each cycle with `cmp_valid` high changes `trim_code` by one, visible in the next cycle. The code goes up by one for `cmp_decision`=1 and down by one for 0. It saturates at 31 and at 0. A cycle with `cmp_valid` low leaves the code unchanged.
- R6: The 32nd accepted decision moves the block to `ST_DONE`. There `cal_done` is high, `cmp_clk_en` and `cal_mode` are low, and further `cmp_valid` pulses leave `trim_code` unchanged.
- R7: Bit i of the trim code weighs 2^i units. `neg_ref_hi[i]` equals `trim_code[i]` and `pos_ref_hi[i]` equals its inverse, where 1 means the element goes to the top reference. The two arrays are thus always on opposite references: a code bit of 1 sends the positive element low and the negative element high.
- R8: `cal_en` low at a clock edge returns the block to `ST_IDLE` from any state with `cal_done` low. The block keeps `trim_code`, and `cmp_valid` pulses in `ST_IDLE` leave the code unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock; all state changes on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| cal_en | input | 1 | Calibration enable |
| cmp_valid | input | 1 | Comparator decision strobe, one cycle per decision |
| cmp_decision | input | 1 | Comparator decision (1 = positive side higher) |
| cal_mode | output | 1 | Selects the calibration sample controls over the normal ones |
| cal_samp | output | 1 | Calibration sample control (references to bottom plates) |
| cal_short | output | 1 | Calibration top-plate short control |
| sw_cm | output | 11 | Per-element common-mode switch commands, bit k for element k |
| cmp_clk_en | output | 1 | Comparator clock enable |
| cal_done | output | 1 | Calibration complete |
| trim_code | output | 5 | Stored trim code |
| pos_ref_hi | output | 5 | Positive-array trim element to top reference (1) or bottom (0) |
| neg_ref_hi | output | 5 | Negative-array trim element to top reference (1) or bottom (0) |

## Verification
The upper saturation is hardest to reach from the ports. Reaching code 31 takes 31 consecutive up-decisions, and the step limit must not end the phase before the clamp is tested. The stimulus therefore spends 31 of the 32 strobes climbing and the last one pressing against the ceiling. A separate run holds the decision at 0 to exercise the floor. Aborting mid-trim and strobing in idle and after completion show that the held code survives everything except a fresh entry into `ST_REF_SAMPLE`.

// File: rtl/ocal_pkg.sv
package ocal_pkg;

    typedef enum logic [2:0] {
        ST_IDLE       = 3'd0,
        ST_REF_SAMPLE = 3'd1,
        ST_DISCHARGE  = 3'd2,
        ST_TRIM       = 3'd3,
        ST_DONE       = 3'd4
    } ocal_state_e;

    // which common-mode pattern the switch map should drive
    typedef enum logic [1:0] {
        CM_NONE  = 2'd0,
        CM_ALL   = 2'd1,
        CM_UPPER = 2'd2
    } cm_mode_e;

endpackage

// File: rtl/ocal_phase_fsm.sv
module ocal_phase_fsm
    import ocal_pkg::*;
#(
    parameter int SAMPLE_CYCLES = 2
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     cal_en,
    input  logic     cmp_valid,
    input  logic     last_step,
    output logic     cal_mode,
    output logic     cal_samp,
    output logic     cal_short,
    output logic     cmp_clk_en,
    output logic     cal_done,
    output logic     clear_code,
    output logic     step_en,
    output cm_mode_e cm_mode
);

    localparam int TW = (SAMPLE_CYCLES > 1) ? $clog2(SAMPLE_CYCLES) : 1;
    localparam logic [TW-1:0] T_LAST = TW'(SAMPLE_CYCLES - 1);

    ocal_state_e state_q, state_d;
    logic [TW-1:0] timer_q;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:       if (cal_en) state_d = ST_REF_SAMPLE;
            ST_REF_SAMPLE: begin
                if (!cal_en)               state_d = ST_IDLE;
                else if (timer_q == T_LAST) state_d = ST_DISCHARGE;
            end
            ST_DISCHARGE: state_d = cal_en ? ST_TRIM : ST_IDLE;
            ST_TRIM: begin
                if (!cal_en)        state_d = ST_IDLE;
                else if (last_step) state_d = ST_DONE;
            end
            ST_DONE:       if (!cal_en) state_d = ST_IDLE;
            default:       state_d = ST_IDLE;
        endcase
    end

    // state register and reference-sample phase timer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            timer_q <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_REF_SAMPLE && state_d == ST_REF_SAMPLE)
                timer_q <= timer_q + 1'b1;
            else
                timer_q <= '0;
        end
    end

    // output decode (Moore, plus enable-qualified strobes)
    always_comb begin
        cal_mode   = 1'b0;
        cal_samp   = 1'b0;
        cal_short  = 1'b0;
        cmp_clk_en = 1'b0;
        cal_done   = 1'b0;
        clear_code = 1'b0;
        step_en    = 1'b0;
        cm_mode    = CM_NONE;
        unique case (state_q)
            ST_IDLE: clear_code = cal_en;
            ST_REF_SAMPLE: begin
                cal_mode  = 1'b1;
                cal_samp  = 1'b1;
                cal_short = 1'b1;
            end
            ST_DISCHARGE: begin
                cal_mode  = 1'b1;
                cal_short = 1'b1;
                cm_mode   = CM_ALL;
            end
            ST_TRIM: begin
                cal_mode   = 1'b1;
                cmp_clk_en = 1'b1;
                cm_mode    = CM_UPPER;
                step_en    = cmp_valid && cal_en;
            end
            ST_DONE: cal_done = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/ocal_trim_acc.sv
module ocal_trim_acc #(
    parameter int TRIM_W  = 5,
    parameter int NUM_CMP = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              step_en,
    input  logic              step_up,
    output logic [TRIM_W-1:0] code,
    output logic              last_step
);

    localparam int CW = $clog2(NUM_CMP + 1);
    localparam logic [TRIM_W-1:0] CODE_MAX = {TRIM_W{1'b1}};
    localparam logic [CW-1:0] CNT_LAST = CW'(NUM_CMP - 1);

    logic [CW-1:0]     steps_q;
    logic [TRIM_W-1:0] code_q;

    assign code      = code_q;
    assign last_step = step_en && (steps_q == CNT_LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q  <= '0;
            steps_q <= '0;
        end else if (clear) begin
            code_q  <= '0;
            steps_q <= '0;
        end else if (step_en) begin
            steps_q <= steps_q + 1'b1;
            if (step_up) begin
                if (code_q != CODE_MAX) code_q <= code_q + 1'b1;
            end else begin
                if (code_q != '0) code_q <= code_q - 1'b1;
            end
        end
    end

endmodule

// File: rtl/ocal_switch_map.sv
module ocal_switch_map
    import ocal_pkg::*;
#(
    parameter int TRIM_W = 5,
    parameter int NUM_SW = 11
) (
    input  logic [TRIM_W-1:0] code,
    input  cm_mode_e          cm_mode,
    output logic [TRIM_W-1:0] pos_ref_hi,
    output logic [TRIM_W-1:0] neg_ref_hi,
    output logic [NUM_SW-1:0] sw_cm
);

    // trim elements sit on the lowest TRIM_W switch positions
    for (genvar i = 0; i < TRIM_W; i++) begin : g_trim
        assign neg_ref_hi[i] = code[i];
        assign pos_ref_hi[i] = ~code[i];
        assign sw_cm[i]      = (cm_mode == CM_ALL);
    end

    for (genvar k = TRIM_W; k < NUM_SW; k++) begin : g_rest
        assign sw_cm[k] = (cm_mode == CM_ALL) || (cm_mode == CM_UPPER);
    end

endmodule

// File: rtl/ocal_ctrl.sv
module ocal_ctrl
    import ocal_pkg::*;
#(
    parameter int TRIM_W        = 5,
    parameter int NUM_SW        = 11,
    parameter int NUM_CMP       = 32,
    parameter int SAMPLE_CYCLES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cal_en,
    input  logic              cmp_valid,
    input  logic              cmp_decision,
    output logic              cal_mode,
    output logic              cal_samp,
    output logic              cal_short,
    output logic [NUM_SW-1:0] sw_cm,
    output logic              cmp_clk_en,
    output logic              cal_done,
    output logic [TRIM_W-1:0] trim_code,
    output logic [TRIM_W-1:0] pos_ref_hi,
    output logic [TRIM_W-1:0] neg_ref_hi
);

    logic     clear_code;
    logic     step_en;
    logic     last_step;
    cm_mode_e cm_mode;

    ocal_phase_fsm #(.SAMPLE_CYCLES(SAMPLE_CYCLES)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cal_en     (cal_en),
        .cmp_valid  (cmp_valid),
        .last_step  (last_step),
        .cal_mode   (cal_mode),
        .cal_samp   (cal_samp),
        .cal_short  (cal_short),
        .cmp_clk_en (cmp_clk_en),
        .cal_done   (cal_done),
        .clear_code (clear_code),
        .step_en    (step_en),
        .cm_mode    (cm_mode)
    );

    ocal_trim_acc #(.TRIM_W(TRIM_W), .NUM_CMP(NUM_CMP)) u_acc (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (clear_code),
        .step_en   (step_en),
        .step_up   (cmp_decision),
        .code      (trim_code),
        .last_step (last_step)
    );

    ocal_switch_map #(.TRIM_W(TRIM_W), .NUM_SW(NUM_SW)) u_map (
        .code       (trim_code),
        .cm_mode    (cm_mode),
        .pos_ref_hi (pos_ref_hi),
        .neg_ref_hi (neg_ref_hi),
        .sw_cm      (sw_cm)
    );

endmodule

// File: rtl/ocal_ctrl_chk.sv
module ocal_ctrl_chk #(
    parameter int TRIM_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cal_en,
    input logic              cmp_valid,
    input logic              cal_mode,
    input logic              cal_samp,
    input logic              cal_short,
    input logic              cmp_clk_en,
    input logic              cal_done,
    input logic [TRIM_W-1:0] trim_code,
    input logic [TRIM_W-1:0] pos_ref_hi,
    input logic [TRIM_W-1:0] neg_ref_hi
);

    assert_short_one_cycle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cal_short && !cal_samp) |=> !cal_short);

    assert_trim_phase_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_clk_en |-> (!cal_short && !cal_samp && cal_mode));

    assert_single_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_clk_en && cmp_valid && cal_en) |=>
            ((trim_code == $past(trim_code) + 1'b1) ||
             (trim_code == $past(trim_code) - 1'b1) ||
             (trim_code == $past(trim_code))));

    assert_code_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!(cmp_clk_en && cmp_valid) && !(cal_en && !cal_mode && !cal_done)) |=>
            $stable(trim_code));

    assert_done_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cal_done |-> (!cmp_clk_en && !cal_mode));

    assert_abort_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !cal_en |=> (!cal_mode && !cal_done && !cmp_clk_en));

    // R7: the two arrays never share a reference on any trim element
    always @(posedge clk) begin
        if (rst_n) begin
            assert_opposite_refs_R7: assert ((pos_ref_hi ^ neg_ref_hi) == {TRIM_W{1'b1}});
        end
    end

endmodule

bind ocal_ctrl ocal_ctrl_chk #(.TRIM_W(TRIM_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cal_en     (cal_en),
    .cmp_valid  (cmp_valid),
    .cal_mode   (cal_mode),
    .cal_samp   (cal_samp),
    .cal_short  (cal_short),
    .cmp_clk_en (cmp_clk_en),
    .cal_done   (cal_done),
    .trim_code  (trim_code),
    .pos_ref_hi (pos_ref_hi),
    .neg_ref_hi (neg_ref_hi)
);

// File: tb/tb_ocal_ctrl.sv
`timescale 1ns/1ps
module tb_ocal_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cal_en = 1'b0;
    logic        cmp_valid = 1'b0;
    logic        cmp_decision = 1'b0;
    logic        cal_mode, cal_samp, cal_short, cmp_clk_en, cal_done;
    logic [10:0] sw_cm;
    logic [4:0]  trim_code, pos_ref_hi, neg_ref_hi;

    int n_chk = 0;
    int n_bad = 0;
    int model = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    ocal_ctrl dut (
        .clk(clk), .rst_n(rst_n), .cal_en(cal_en), .cmp_valid(cmp_valid),
        .cmp_decision(cmp_decision), .cal_mode(cal_mode), .cal_samp(cal_samp),
        .cal_short(cal_short), .sw_cm(sw_cm), .cmp_clk_en(cmp_clk_en),
        .cal_done(cal_done), .trim_code(trim_code), .pos_ref_hi(pos_ref_hi),
        .neg_ref_hi(neg_ref_hi)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic chk_refs(input string tag);
        chk({tag, " R7 neg_ref_hi"}, neg_ref_hi, model);
        chk({tag, " R7 pos_ref_hi"}, pos_ref_hi, (~model) & 31);
    endtask

    // advance one cycle, sampling at the following falling edge
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic strobe(input logic d);
        cmp_valid = 1'b1;
        cmp_decision = d;
        tick();
        cmp_valid = 1'b0;
        if (d) model = (model < 31) ? model + 1 : 31;
        else   model = (model > 0) ? model - 1 : 0;
    endtask

    // enable calibration and walk to the trim phase
    task automatic enter_trim();
        cal_en = 1'b1;
        tick(); tick(); tick(); tick();
        model = 0;
    endtask

    task automatic t_reset();
        chk("R1 cal_mode", cal_mode, 0);
        chk("R1 samp/short", {cal_samp, cal_short}, 0);
        chk("R1 cmp_clk_en/done", {cmp_clk_en, cal_done}, 0);
        chk("R1 sw_cm", sw_cm, 0);
        chk("R1 trim_code", trim_code, 0);
    endtask

    task automatic t_entry();
        cal_en = 1'b1;
        tick();
        chk("R2 first cycle ctrls", {cal_mode, cal_samp, cal_short}, 7);
        chk("R2 sw_cm", sw_cm, 0);
        chk("R2 code cleared", trim_code, 0);
        tick();
        chk("R2 second cycle ctrls", {cal_mode, cal_samp, cal_short}, 7);
        tick();
        chk("R3 discharge samp/short", {cal_samp, cal_short}, 1);
        chk("R3 discharge sw_cm", sw_cm, 11'h7FF);
        chk("R3 discharge cmp_clk_en", cmp_clk_en, 0);
        tick();
        chk("R4 trim cmp_clk_en/mode", {cmp_clk_en, cal_mode}, 3);
        chk("R4 trim samp/short", {cal_samp, cal_short}, 0);
        chk("R4 trim sw_cm", sw_cm, 11'h7E0);
        model = 0;
    endtask

    // 31 ups then one more against the ceiling
    task automatic t_saturate_high();
        for (int i = 0; i < 31; i++) strobe(1'b1);
        chk("R5 climb to 31", trim_code, 31);
        chk("R6 not done after 31", cal_done, 0);
        strobe(1'b1);
        chk("R5 clamp at 31", trim_code, 31);
        chk("R6 done after 32", cal_done, 1);
        chk("R6 cmp_clk_en off", {cmp_clk_en, cal_mode}, 0);
        chk_refs("high");
        strobe(1'b0);
        strobe(1'b0);
        chk("R6 strobes after done ignored", trim_code, 31);
        cal_en = 1'b0;
        tick();
        chk("R8 done clears on disable", cal_done, 0);
        chk("R8 code kept after done", trim_code, 31);
    endtask

    task automatic t_saturate_low();
        enter_trim();
        chk("R2 code restarted", trim_code, 0);
        for (int i = 0; i < 32; i++) begin
            strobe(1'b0);
            if (i == 0) chk("R5 clamp at 0", trim_code, 0);
        end
        chk("R6 done after 32 zeros", cal_done, 1);
        chk("R5 final zero", trim_code, 0);
        cal_en = 1'b0;
        tick();
    endtask

    // mixed decisions with idle gaps between strobes
    task automatic t_mixed();
        enter_trim();
        for (int i = 0; i < 32; i++) begin
            strobe((i < 12) ? 1'b1 : ((i % 3) != 0));
            if (i == 5) begin
                tick(); tick();
                chk("R5 no strobe holds code", trim_code, model);
            end
            if (i == 20) chk_refs("mixed");
        end
        chk("R5 mixed final code", trim_code, model);
        chk("R6 mixed done", cal_done, 1);
        cal_en = 1'b0;
        tick();
    endtask

    task automatic t_abort();
        enter_trim();
        for (int i = 0; i < 5; i++) strobe(1'b1);
        chk("R5 five ups", trim_code, 5);
        cal_en = 1'b0;
        tick();
        chk("R8 abort idle", {cal_mode, cmp_clk_en, cal_done}, 0);
        chk("R8 abort code kept", trim_code, 5);
        strobe(1'b1);
        model = 5;
        chk("R8 idle strobe ignored", trim_code, 5);
        chk_refs("abort");
        cal_en = 1'b1;
        tick();
        chk("R2 reentry clears code", trim_code, 0);
        cal_en = 1'b0;
        tick();
        chk("R8 abort in sample phase", {cal_mode, cal_samp, cal_short}, 0);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        tick(); tick();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_entry();
        t_saturate_high();
        t_saturate_low();
        t_mixed();
        t_abort();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule